// File: doc/BRIEF.md
# Entropy Pool Scheduler and Reseed Selector

This block is the control core of a multi-pool entropy accumulator. Entropy events arrive one byte at a time over a ready/valid handshake. The block deals them out across 32 pools in strict rotation. For each accepted byte it asks an external hash engine to fold the byte into the chosen pool. The engine reads the stored 256-bit pool value, appends the byte, hashes the 264-bit string and writes the 256-bit digest back into the same pool. The block keeps a per-pool flag that tells the engine whether the pool still holds its cleared (all-zero) value.

The block counts how many updates pool 0 has completed. Once pool 0 has enough credit (each byte counts as 4 bits, so 64 updates make a full 256-bit key) and the generator asks for fresh key material, the block starts a reseed. It increments a reseed counter and computes which pools take part: pool i joins when 2^i divides the new counter value. It then asks the engine to double-hash the selected pools into a seed and clear them.

Only one operation is outstanding at any time. This keeps an event update and a reseed read from ever touching a pool together. Events that arrive during a busy period are held back and never dropped.

Top module: `entropy_pool_scheduler`

## Requirements
- R1: While and after reset, evtReady is 1, hashReq and mixReq are 0, seedReady is 0 and reseedCount is 0.
- R2: The k-th accepted event, counting from 0 after reset, is sent to pool k mod 32 on hashPool, with 31 wrapping to 0. hashByte carries the byte that was presented on evtData at acceptance.
- R3: evtReady is 0 while a pool update or a reseed is outstanding. An event held off this way is accepted later with its byte intact.
- R4: hashReq, once raised, stays high with a stable hashPool until hashAck. hashReq and mixReq are never high together.
- R5: hashFresh is 1 exactly when the addressed pool has completed no update since reset or since the last reseed whose mask included it.
- R6: seedReady rises once pool 0 has completed 64 updates and stays high for any number of further pool-0 updates: the credit saturates and does not wrap.
- R7: A reseed starts from idle only when reseedReq and seedReady are both 1. It then wins over a waiting event, and evtReady is 0 in that cycle. With seedReady low, reseedReq has no effect.
- R8: Each reseed increments reseedCount by one; the new value is visible when mixReq rises.
- R9: During a reseed, bit i of mixMask is 1 exactly when 2^i divides the new reseedCount. Bits 0 up to the count of trailing zeros are set, capped at bit 31, and bit 0 is always set.
- R10: On mixAck, the pool-0 credit clears (seedReady goes low) and every pool in mixMask becomes fresh again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Entropy byte offered |
| evtData | input | 8 | Entropy byte |
| evtReady | output | 1 | Byte accepted on this edge when evtValid is high |
| hashReq | output | 1 | Pool update request to the hash engine |
| hashAck | input | 1 | Hash engine finished the pool update |
| hashPool | output | 5 | Pool index for the update |
| hashByte | output | 8 | Byte to fold into the pool |
| hashFresh | output | 1 | Addressed pool holds its cleared value |
| reseedReq | input | 1 | Generator asks for a new seed |
| seedReady | output | 1 | Pool 0 holds enough credit for a reseed |
| mixReq | output | 1 | Reseed request: combine and clear the masked pools |
| mixAck | input | 1 | Reseed combine and clear finished |
| mixMask | output | 32 | Pools taking part in the current reseed |
| reseedCount | output | 32 | Number of reseeds since reset |

## Verification
The situations hardest to reach from the ports are the upper mask bits and the saturation of the pool-0 credit. A mask with bit 3 set needs the eighth reseed, and each reseed needs 64 pool-0 updates, which means 2048 events per reseed. Holding the credit past the point where an unsaturated 7-bit count would wrap takes 130 pool-0 updates without a reseed. The bench drives events through a two-cycle handshake loop that acknowledges each hash request at once. It keeps its own model of the rotation pointer, the credit, the fresh flags and the reseed count. It pushes through nine reseeds with a saturation run before the last, and also places an event and a reseed request in the same cycle to check ordering and hold-off.

// File: rtl/entropy_sched_pkg.sv
package entropy_sched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HASH = 2'd1,
    ST_MIX  = 2'd2
  } schedState_t;

  // Strobes from the sequencer to the datapath, at most one set per cycle.
  typedef struct packed {
    logic acceptEvt;  // latch byte, bind it to the rotation pointer
    logic hashDone;   // pool update finished
    logic startMix;   // bump reseed count, capture selection mask
    logic mixDone;    // selected pools consumed and cleared
  } schedStrobe_t;

endpackage

// File: rtl/pool_sched_ctrl.sv
module pool_sched_ctrl
  import entropy_sched_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         evtValid,
  input  logic         reseedReq,
  input  logic         seedReady,
  input  logic         hashAck,
  input  logic         mixAck,
  output logic         evtReady,
  output logic         hashReq,
  output logic         mixReq,
  output schedStrobe_t strobe
);

  schedState_t stateQ, stateD;
  logic        isIdle;
  logic        mixGo;

  always_comb begin
    isIdle = (stateQ == ST_IDLE);
    mixGo  = isIdle && reseedReq && seedReady;

    strobe.startMix  = mixGo;
    strobe.acceptEvt = isIdle && !mixGo && evtValid;
    strobe.hashDone  = (stateQ == ST_HASH) && hashAck;
    strobe.mixDone   = (stateQ == ST_MIX) && mixAck;

    evtReady = isIdle && !(reseedReq && seedReady);
    hashReq  = (stateQ == ST_HASH);
    mixReq   = (stateQ == ST_MIX);

    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (mixGo)              stateD = ST_MIX;
        else if (evtValid)      stateD = ST_HASH;
      end
      ST_HASH: if (hashAck)     stateD = ST_IDLE;
      ST_MIX:  if (mixAck)      stateD = ST_IDLE;
      default:                  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  // R4: a single pool user at any time
  assert_one_owner_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(hashReq && mixReq));

  // R4: the update request is held until acknowledged
  assert_hash_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    hashReq && !hashAck |=> hashReq);

  // R3: an accepted byte always leads to a pool update request
  assert_accept_to_hash_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.acceptEvt |=> hashReq);

  // R7: a reseed only begins after a qualified request
  assert_mix_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mixReq) |-> $past(reseedReq && seedReady));

endmodule

// File: rtl/pool_sched_dp.sv
module pool_sched_dp
  import entropy_sched_pkg::*;
#(
  parameter int NUM_POOLS  = 32,
  parameter int RCNT_W     = 32,
  parameter int MIN_EVENTS = 64,
  parameter int EVT_W      = 8,
  localparam int PTR_W     = $clog2(NUM_POOLS),
  localparam int CNT_W     = $clog2(MIN_EVENTS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  schedStrobe_t         strobe,
  input  logic [EVT_W-1:0]     evtData,
  output logic [PTR_W-1:0]     hashPool,
  output logic [EVT_W-1:0]     hashByte,
  output logic                 hashFresh,
  output logic [NUM_POOLS-1:0] mixMask,
  output logic [RCNT_W-1:0]    reseedCount,
  output logic                 seedReady
);

  localparam logic [PTR_W-1:0] LAST_POOL = PTR_W'(NUM_POOLS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(MIN_EVENTS);

  logic [PTR_W-1:0]     ptrQ;
  logic [PTR_W-1:0]     poolQ;
  logic [EVT_W-1:0]     byteQ;
  logic [RCNT_W-1:0]    rQ;
  logic [CNT_W-1:0]     cnt0Q;
  logic [NUM_POOLS-1:0] validQ;
  logic [NUM_POOLS-1:0] maskQ;
  logic [RCNT_W-1:0]    newR;
  logic [NUM_POOLS-1:0] nextMask;

  assign newR = rQ + RCNT_W'(1);

  // Pool i joins when the low i bits of the new count are all zero.
  for (genvar i = 0; i < NUM_POOLS; i++) begin : g_sel
    if (i == 0) begin : g_base
      assign nextMask[i] = 1'b1;
    end else if (i <= RCNT_W) begin : g_div
      assign nextMask[i] = (newR[i-1:0] == '0);
    end else begin : g_wrap
      assign nextMask[i] = (newR == '0);
    end
  end

  // Rotation pointer and latched event
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ  <= '0;
      poolQ <= '0;
      byteQ <= '0;
    end else if (strobe.acceptEvt) begin
      poolQ <= ptrQ;
      byteQ <= evtData;
      ptrQ  <= (ptrQ == LAST_POOL) ? '0 : ptrQ + PTR_W'(1);
    end
  end

  // Reseed count and captured selection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rQ    <= '0;
      maskQ <= '0;
    end else if (strobe.startMix) begin
      rQ    <= newR;
      maskQ <= nextMask;
    end
  end

  // Pool-0 credit, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt0Q <= '0;
    end else if (strobe.mixDone) begin
      cnt0Q <= '0;
    end else if (strobe.hashDone && poolQ == '0 && cnt0Q != CNT_FULL) begin
      cnt0Q <= cnt0Q + CNT_W'(1);
    end
  end

  // Per-pool "holds data" flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else if (strobe.mixDone) begin
      validQ <= validQ & ~maskQ;
    end else if (strobe.hashDone) begin
      validQ[poolQ] <= 1'b1;
    end
  end

  assign hashPool    = poolQ;
  assign hashByte    = byteQ;
  assign hashFresh   = ~validQ[poolQ];
  assign mixMask     = maskQ;
  assign reseedCount = rQ;
  assign seedReady   = (cnt0Q == CNT_FULL);

  // R6: credit never passes its ceiling
  assert_credit_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    cnt0Q <= CNT_FULL);

  // R8: each reseed adds exactly one to the count
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.startMix |=> reseedCount == $past(reseedCount) + RCNT_W'(1));

  // R9: pool 0 is part of every reseed
  assert_mask_base_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mixDone |-> mixMask[0]);

  // R10: consuming pool 0 removes its credit
  assert_credit_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mixDone |=> !seedReady);

  // R5: an updated pool is no longer fresh
  assert_fresh_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hashDone |=> !hashFresh);

endmodule

// File: rtl/entropy_pool_scheduler.sv
module entropy_pool_scheduler
  import entropy_sched_pkg::*;
#(
  parameter int NUM_POOLS  = 32,
  parameter int RCNT_W     = 32,
  parameter int MIN_EVENTS = 64,
  parameter int EVT_W      = 8,
  localparam int PTR_W     = $clog2(NUM_POOLS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 evtValid,
  input  logic [EVT_W-1:0]     evtData,
  output logic                 evtReady,
  output logic                 hashReq,
  input  logic                 hashAck,
  output logic [PTR_W-1:0]     hashPool,
  output logic [EVT_W-1:0]     hashByte,
  output logic                 hashFresh,
  input  logic                 reseedReq,
  output logic                 seedReady,
  output logic                 mixReq,
  input  logic                 mixAck,
  output logic [NUM_POOLS-1:0] mixMask,
  output logic [RCNT_W-1:0]    reseedCount
);

  schedStrobe_t strobe;

  pool_sched_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .evtValid  (evtValid),
    .reseedReq (reseedReq),
    .seedReady (seedReady),
    .hashAck   (hashAck),
    .mixAck    (mixAck),
    .evtReady  (evtReady),
    .hashReq   (hashReq),
    .mixReq    (mixReq),
    .strobe    (strobe)
  );

  pool_sched_dp #(
    .NUM_POOLS  (NUM_POOLS),
    .RCNT_W     (RCNT_W),
    .MIN_EVENTS (MIN_EVENTS),
    .EVT_W      (EVT_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .evtData     (evtData),
    .hashPool    (hashPool),
    .hashByte    (hashByte),
    .hashFresh   (hashFresh),
    .mixMask     (mixMask),
    .reseedCount (reseedCount),
    .seedReady   (seedReady)
  );

  // R4: the pool index is held while an update is outstanding
  assert_pool_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    hashReq && !hashAck |=> $stable(hashPool));

endmodule

// File: tb/test_entropy_pool_scheduler.sv
`timescale 1ns/1ps
module test_entropy_pool_scheduler;

  logic        clk = 1'b0;
  logic        rstN;
  logic        evtValid;
  logic [7:0]  evtData;
  logic        evtReady;
  logic        hashReq;
  logic        hashAck;
  logic [4:0]  hashPool;
  logic [7:0]  hashByte;
  logic        hashFresh;
  logic        reseedReq;
  logic        seedReady;
  logic        mixReq;
  logic        mixAck;
  logic [31:0] mixMask;
  logic [31:0] reseedCount;

  always #4 clk = ~clk;

  entropy_pool_scheduler i_entropy_pool_scheduler (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtData(evtData),
    .evtReady(evtReady), .hashReq(hashReq), .hashAck(hashAck),
    .hashPool(hashPool), .hashByte(hashByte), .hashFresh(hashFresh),
    .reseedReq(reseedReq), .seedReady(seedReady), .mixReq(mixReq),
    .mixAck(mixAck), .mixMask(mixMask), .reseedCount(reseedCount)
  );

  int          nChecks = 0;
  int          nFails  = 0;
  int          expPtr  = 0;
  int          expCnt0 = 0;
  logic [31:0] expValid = '0;
  longint      expR    = 0;
  int          evtSeq  = 0;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] maskFor(input longint r);
    logic [31:0] m;
    for (int i = 0; i < 32; i++)
      m[i] = ((r & ((64'd1 << i) - 1)) == 0);
    return m;
  endfunction

  function automatic logic [7:0] byteFor(input int seq);
    return 8'(seq * 37 + 11);
  endfunction

  // One event through the handshake and the hash port.
  task automatic sendEvent(input int holdCycles);
    logic [7:0] b;
    b = byteFor(evtSeq);
    evtSeq++;
    evtData  = b;
    evtValid = 1'b1;
    #1;
    while (!evtReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    evtValid = 1'b0;
    check("R3", "evtReady while updating", 64'(evtReady), 64'd0);
    check("R4", "hashReq raised", 64'(hashReq), 64'd1);
    check("R4", "mixReq idle during update", 64'(mixReq), 64'd0);
    check("R2", "hashPool", 64'(hashPool), 64'(expPtr));
    check("R2", "hashByte", 64'(hashByte), 64'(b));
    check("R5", "hashFresh", 64'(hashFresh), 64'(!expValid[expPtr]));
    for (int h = 0; h < holdCycles; h++) begin
      @(negedge clk);
      check("R4", "hashReq held", 64'(hashReq), 64'd1);
      check("R4", "hashPool held", 64'(hashPool), 64'(expPtr));
    end
    hashAck = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hashAck = 1'b0;
    expValid[expPtr] = 1'b1;
    if (expPtr == 0 && expCnt0 < 64) expCnt0++;
    expPtr = (expPtr + 1) % 32;
    check("R6", "seedReady", 64'(seedReady), 64'(expCnt0 == 64));
    check("R3", "evtReady after update", 64'(evtReady), 64'd1);
  endtask

  task automatic fillPool0();
    while (expCnt0 < 64) sendEvent(0);
  endtask

  task automatic doReseed();
    logic [31:0] m;
    reseedReq = 1'b1;
    #1;
    check("R7", "evtReady yields to reseed", 64'(evtReady), 64'd0);
    @(posedge clk);
    @(negedge clk);
    reseedReq = 1'b0;
    expR++;
    m = maskFor(expR);
    check("R7", "mixReq raised", 64'(mixReq), 64'd1);
    check("R4", "hashReq idle during reseed", 64'(hashReq), 64'd0);
    check("R8", "reseedCount", 64'(reseedCount), 64'(expR));
    check("R9", "mixMask", 64'(mixMask), 64'(m));
    check("R3", "evtReady during reseed", 64'(evtReady), 64'd0);
    mixAck = 1'b1;
    @(posedge clk);
    @(negedge clk);
    mixAck = 1'b0;
    expValid = expValid & ~m;
    expCnt0 = 0;
    check("R10", "seedReady cleared", 64'(seedReady), 64'd0);
    check("R4", "mixReq dropped", 64'(mixReq), 64'd0);
  endtask

  task automatic testReset();
    rstN = 1'b0; evtValid = 1'b0; evtData = '0; hashAck = 1'b0;
    reseedReq = 1'b0; mixAck = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "evtReady in reset", 64'(evtReady), 64'd1);
    check("R1", "hashReq in reset", 64'(hashReq), 64'd0);
    check("R1", "mixReq in reset", 64'(mixReq), 64'd0);
    check("R1", "seedReady in reset", 64'(seedReady), 64'd0);
    check("R1", "reseedCount in reset", 64'(reseedCount), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "evtReady after reset", 64'(evtReady), 64'd1);
  endtask

  // Rotation across all pools and the first fill of pool 0.
  task automatic testRotation();
    sendEvent(3);
    for (int k = 1; k < 2016; k++) sendEvent(0);
    check("R6", "seedReady one short", 64'(seedReady), 64'd0);
    check("R2", "pointer back at pool 0", 64'(expPtr), 64'd0);
  endtask

  task automatic testReseedIgnored();
    reseedReq = 1'b1;
    #1;
    check("R7", "evtReady with unqualified request", 64'(evtReady), 64'd1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R7", "no reseed without credit", 64'(mixReq), 64'd0);
      check("R7", "count unchanged", 64'(reseedCount), 64'(expR));
    end
    reseedReq = 1'b0;
    @(negedge clk);
  endtask

  // Event and reseed request raised together: reseed first, byte kept.
  task automatic testPriority();
    fillPool0();
    evtData  = byteFor(evtSeq);
    evtValid = 1'b1;
    doReseed();
    sendEvent(0);
  endtask

  task automatic testMaskSweep();
    for (int r = 2; r <= 8; r++) begin
      fillPool0();
      doReseed();
    end
  endtask

  // Credit past the wrap point of an unsaturated 7-bit counter.
  task automatic testSaturation();
    fillPool0();
    for (int k = 0; k < 66 * 32; k++) sendEvent(0);
    check("R6", "seedReady after 130 pool-0 updates", 64'(seedReady), 64'd1);
    doReseed();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R1-watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    testReset();
    testRotation();
    testReseedIgnored();
    testPriority();
    testMaskSweep();
    testSaturation();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule